// File: doc/BRIEF.md
# Adaptive Idle-Timeout Power Controller for a Second-Level Cache Data Array

This block decides when the data array of a second-level cache may be put into its low-leakage state. It counts the cycles since the most recent access. Once that count passes a timeout threshold, it raises a shutdown signal for the data array only. The tag array stays powered, so a later lookup can still be resolved as a hit or a miss. A new access while the array is down clears shutdown and raises a wakeup request. The access is stalled until the power domain reports that it is ready again.

The threshold has two sources, chosen by a mode input:

- **Fixed mode:** the threshold follows a preset break-even idle length supplied on an input.
- **Feedback mode:** the threshold is retuned once per window of `WIN_LEN` cycles. The change is the difference between the window's miss count and a setpoint, shifted left by a gain amount. The result is kept between a programmable floor and the 16-bit maximum.

Top module: `l2_idle_power_ctrl`

## Requirements
- R1: During and directly after synchronous active-low reset, `shutdown`, `wakeup` and `stall` are 0, and `threshold` equals `INIT_THR` (default 256).
- R2: An idle count is cleared at every clock edge where `acc_valid` or `wakeup` is 1, and otherwise increases by one per edge, saturating at its maximum. `shutdown` becomes 1 at the first edge where the idle count is strictly greater than `threshold`. It then stays 1 until an access arrives.
- R3: An edge that samples `acc_valid`=1 while `shutdown`=1 clears `shutdown` and sets `wakeup`.
- R4: `wakeup` stays 1 until an edge samples `pwr_ready`=1, and is 0 after that edge. `stall` = `wakeup` OR (`acc_valid` AND `shutdown`), combinationally.
- R5: With `fb_mode`=0, `threshold` takes the value of `fixed_thr` sampled at the previous edge.
- R6: A window counter runs from reset. At the last cycle of each window (cycle `WIN_LEN`-1 counted from 0), with `fb_mode`=1, the threshold becomes threshold + ((miss count − `setpoint`) << `gain`). At all other edges in feedback mode, the threshold holds.
- R7: The updated feedback threshold is clamped to 65535 above and to `min_thr` below.
- R8: The miss count increases only at edges where `acc_valid`=1, `acc_miss`=1 and `stall`=0. Hits and stalled repeats add nothing. At a window end, the update uses the count before that edge, and the count restarts at 0, or at 1 if that same edge accepts a miss.
- R9: While `wakeup` is 1, `shutdown` is 0 and the idle count is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | A request reaches the cache this cycle |
| acc_miss | input | 1 | 1 when the tag lookup for the request missed |
| pwr_ready | input | 1 | The data array is powered and usable |
| fb_mode | input | 1 | 0: fixed threshold, 1: feedback-tuned threshold |
| fixed_thr | input | 16 | Preset break-even idle length for fixed mode |
| min_thr | input | 16 | Lower clamp for the feedback threshold |
| setpoint | input | 13 | Target misses per window |
| gain | input | 4 | Left-shift amount applied to the miss error |
| shutdown | output | 1 | Put the data array into its low-leakage state |
| wakeup | output | 1 | Request to repower the data array |
| stall | output | 1 | The current request must be held |
| threshold | output | 16 | Current idle timeout threshold |

## Verification
Two functions can act on the same edge: the window-end retune of the threshold and the acceptance of a miss. When they coincide, that miss must go into the next window rather than the one being closed. The bench provokes this with long runs of dense random misses across several window boundaries, and also with stalls and wakeups, so that some boundaries carry an accepted miss and others carry a stalled repeat. A behavioural reference model predicts the threshold every cycle. A miss counted in the wrong window therefore shows up as a threshold mismatch at the following window end.

// File: rtl/l2pc_pkg.sv
// Shared types and helpers for the L2 idle power controller.
// Assumes a 16-bit threshold and a signed working width wide enough for
// any miss error shifted by the largest gain.
package l2pc_pkg;
    localparam int THR_W  = 16;
    localparam int CALC_W = 34;

    typedef enum logic {
        MODE_FIXED    = 1'b0,
        MODE_FEEDBACK = 1'b1
    } thr_mode_e;

    // Clamp a signed candidate threshold into [lo, 2^THR_W - 1].
    function automatic logic [THR_W-1:0] clamp_thr(
        input logic signed [CALC_W-1:0] cand,
        input logic [THR_W-1:0]         lo
    );
        logic signed [CALC_W-1:0] hi_s;
        logic signed [CALC_W-1:0] lo_s;
        hi_s = $signed({{(CALC_W-THR_W){1'b0}}, {THR_W{1'b1}}});
        lo_s = $signed({{(CALC_W-THR_W){1'b0}}, lo});
        if (cand > hi_s)      return {THR_W{1'b1}};
        else if (cand < lo_s) return lo;
        else                  return cand[THR_W-1:0];
    endfunction
endpackage

// File: rtl/l2pc_idle_gate.sv
// Idle timer, shutdown flag and wakeup handshake.
// Assumes the requester keeps acc_valid high while stall is high.
module l2pc_idle_gate #(
    parameter int THR_W  = 16,
    parameter int IDLE_W = THR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             pwr_ready,
    input  logic [THR_W-1:0] thr,
    output logic             sd_q,
    output logic             wake_q,
    output logic             stall
);
    localparam logic [IDLE_W-1:0] IDLE_MAX = {IDLE_W{1'b1}};

    logic [IDLE_W-1:0] idle_q;
    logic              expired;

    // Stall while waking up, or when a request finds the array off.
    assign stall   = wake_q | (acc_valid & sd_q);
    assign expired = idle_q > {{(IDLE_W-THR_W){1'b0}}, thr};

    // Idle counter: cleared by activity, saturating otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                  idle_q <= '0;
        else if (acc_valid | wake_q) idle_q <= '0;
        else if (idle_q != IDLE_MAX) idle_q <= idle_q + 1'b1;
    end

    // Shutdown flag: set on timeout, cleared by any access or pending wake.
    always_ff @(posedge clk) begin
        if (!rst_n)                  sd_q <= 1'b0;
        else if (acc_valid | wake_q) sd_q <= 1'b0;
        else if (expired)            sd_q <= 1'b1;
    end

    // Wakeup request: raised by an access to a sleeping array, held until ready.
    always_ff @(posedge clk) begin
        if (!rst_n)                 wake_q <= 1'b0;
        else if (wake_q)            wake_q <= !pwr_ready;
        else if (acc_valid && sd_q) wake_q <= 1'b1;
    end

    p_access_wakes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && sd_q) |=> (!sd_q && wake_q));
    p_wake_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_q && !pwr_ready) |=> wake_q);
    p_no_sd_in_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> !sd_q);
endmodule

// File: rtl/l2pc_miss_window.sv
// Free-running window counter and per-window count of accepted misses.
// Assumes WIN_LEN is a power of two; a miss on the closing edge opens the next window.
module l2pc_miss_window #(
    parameter int WIN_LEN = 4096,
    parameter int WIN_W   = $clog2(WIN_LEN),
    parameter int MISS_W  = WIN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_evt,
    output logic              win_end,
    output logic [MISS_W-1:0] miss_cnt
);
    localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_LEN - 1);

    logic [WIN_W-1:0] win_q;

    assign win_end = (win_q == LAST);

    // Window position counter.
    always_ff @(posedge clk) begin
        if (!rst_n)       win_q <= '0;
        else if (win_end) win_q <= '0;
        else              win_q <= win_q + 1'b1;
    end

    // Miss counter: restarts at each window end, keeping a same-edge miss.
    always_ff @(posedge clk) begin
        if (!rst_n)        miss_cnt <= '0;
        else if (win_end)  miss_cnt <= MISS_W'(miss_evt);
        else if (miss_evt) miss_cnt <= miss_cnt + 1'b1;
    end

    p_win_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (miss_cnt <= MISS_W'(1)));
endmodule

// File: rtl/l2pc_thresh_ctrl.sv
// Threshold register: follows a preset in fixed mode, proportional update per window.
// Assumes gain never exceeds 15 so the shifted error fits the working width.
module l2pc_thresh_ctrl
    import l2pc_pkg::*;
#(
    parameter int                MISS_W   = 13,
    parameter int                GAIN_W   = 4,
    parameter logic [THR_W-1:0]  INIT_THR = 16'd256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  thr_mode_e         mode,
    input  logic [THR_W-1:0]  fixed_thr,
    input  logic [THR_W-1:0]  min_thr,
    input  logic [MISS_W-1:0] setpoint,
    input  logic [GAIN_W-1:0] gain,
    input  logic              win_end,
    input  logic [MISS_W-1:0] miss_cnt,
    output logic [THR_W-1:0]  thr_q
);
    logic signed [MISS_W:0]   err;
    logic signed [CALC_W-1:0] err_ext;
    logic signed [CALC_W-1:0] step;
    logic signed [CALC_W-1:0] cand;
    logic [THR_W-1:0]         tuned;

    // Proportional step: signed miss error scaled by a left shift.
    always_comb begin
        err     = $signed({1'b0, miss_cnt}) - $signed({1'b0, setpoint});
        err_ext = CALC_W'(err);
        step    = err_ext <<< gain;
        cand    = $signed({{(CALC_W-THR_W){1'b0}}, thr_q}) + step;
        tuned   = clamp_thr(cand, min_thr);
    end

    // Threshold register update by mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                  thr_q <= INIT_THR;
        else if (mode == MODE_FIXED) thr_q <= fixed_thr;
        else if (win_end)            thr_q <= tuned;
    end

    p_fixed_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FIXED) |=> (thr_q == $past(fixed_thr)));
    p_hold_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FEEDBACK && !win_end) |=> $stable(thr_q));
    p_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FEEDBACK && win_end) |=> (thr_q >= $past(min_thr)));
endmodule

// File: rtl/l2_idle_power_ctrl.sv
// Top: timeout-based leakage control of an L2 data array with adaptive threshold.
// Assumes the tag array stays powered, so acc_miss is valid on every access.
module l2_idle_power_ctrl
    import l2pc_pkg::*;
#(
    parameter int               WIN_LEN  = 4096,
    parameter int               GAIN_W   = 4,
    parameter logic [15:0]      INIT_THR = 16'd256,
    localparam int              WIN_W    = $clog2(WIN_LEN),
    localparam int              MISS_W   = WIN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_miss,
    input  logic              pwr_ready,
    input  logic              fb_mode,
    input  logic [15:0]       fixed_thr,
    input  logic [15:0]       min_thr,
    input  logic [MISS_W-1:0] setpoint,
    input  logic [GAIN_W-1:0] gain,
    output logic              shutdown,
    output logic              wakeup,
    output logic              stall,
    output logic [15:0]       threshold
);
    logic              win_end;
    logic [MISS_W-1:0] miss_cnt;
    logic              miss_evt;
    thr_mode_e         mode;

    // Only misses of requests that proceed are counted.
    assign miss_evt = acc_valid & acc_miss & ~stall;
    assign mode     = thr_mode_e'(fb_mode);

    l2pc_idle_gate #(.THR_W(THR_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .pwr_ready (pwr_ready),
        .thr       (threshold),
        .sd_q      (shutdown),
        .wake_q    (wakeup),
        .stall     (stall)
    );

    l2pc_miss_window #(.WIN_LEN(WIN_LEN), .WIN_W(WIN_W), .MISS_W(MISS_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .miss_evt (miss_evt),
        .win_end  (win_end),
        .miss_cnt (miss_cnt)
    );

    l2pc_thresh_ctrl #(.MISS_W(MISS_W), .GAIN_W(GAIN_W), .INIT_THR(INIT_THR)) u_thr (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .fixed_thr (fixed_thr),
        .min_thr   (min_thr),
        .setpoint  (setpoint),
        .gain      (gain),
        .win_end   (win_end),
        .miss_cnt  (miss_cnt),
        .thr_q     (threshold)
    );
endmodule

// File: tb/l2_idle_power_ctrl_bench.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module l2_idle_power_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 4096;
    localparam int IDLE_SAT   = 131071;
    localparam int LIMIT      = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_miss = 1'b0;
    logic        pwr_ready = 1'b0;
    logic        fb_mode = 1'b0;
    logic [15:0] fixed_thr = 16'd20;
    logic [15:0] min_thr = 16'd0;
    logic [12:0] setpoint = '0;
    logic [3:0]  gain = '0;
    logic        shutdown, wakeup, stall;
    logic [15:0] threshold;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_en = 1'b0;

    // Model state.
    int m_idle, m_sd, m_wake, m_thr, m_win, m_miss;

    always #(CLK_PERIOD/2) clk = ~clk;

    l2_idle_power_ctrl u_l2_idle_power_ctrl (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_miss(acc_miss),
        .pwr_ready(pwr_ready), .fb_mode(fb_mode), .fixed_thr(fixed_thr),
        .min_thr(min_thr), .setpoint(setpoint), .gain(gain),
        .shutdown(shutdown), .wakeup(wakeup), .stall(stall), .threshold(threshold)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Reference model, advanced once per rising edge.
    always @(posedge clk) begin
        int acc, st, acc_ok, end_w, nt;
        cycles++;
        if (!rst_n) begin
            m_idle = 0; m_sd = 0; m_wake = 0; m_thr = 256; m_win = 0; m_miss = 0;
        end else begin
            acc    = int'(acc_valid);
            st     = (m_wake != 0 || (acc != 0 && m_sd != 0)) ? 1 : 0;
            acc_ok = (acc != 0 && acc_miss && st == 0) ? 1 : 0;
            end_w  = (m_win == WIN - 1) ? 1 : 0;
            if (!fb_mode) m_thr = int'(fixed_thr);
            else if (end_w != 0) begin
                nt = m_thr + (m_miss - int'(setpoint)) * (1 << gain);
                if (nt > 65535) nt = 65535;
                if (nt < int'(min_thr)) nt = int'(min_thr);
                m_thr = nt;
            end
            m_miss = (end_w != 0) ? acc_ok : m_miss + acc_ok;
            m_win  = (end_w != 0) ? 0 : m_win + 1;
            if (m_wake != 0) m_wake = pwr_ready ? 0 : 1;
            else if (acc != 0 && m_sd != 0) m_wake = 1;
            // Shutdown and idle use the pre-edge idle count and wake state.
            if (acc != 0 || m_wake != 0 || st != 0) begin
                m_sd = 0; m_idle = 0;
            end else begin
                if (m_idle > m_thr_prev()) m_sd = 1;
                if (m_idle < IDLE_SAT) m_idle++;
            end
            thr_prev_q = m_thr;
        end
    end

    // The threshold that the design compared against before the edge.
    int thr_prev_q = 256;
    function automatic int m_thr_prev();
        return thr_prev_q;
    endfunction

    // Per-cycle comparison of all outputs against the model.
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk("R2 shutdown", int'(shutdown), m_sd);
            chk("R4 wakeup", int'(wakeup), m_wake);
            chk("R4 stall", int'(stall),
                (m_wake != 0 || (acc_valid && m_sd != 0)) ? 1 : 0);
            chk("R6 R7 threshold", int'(threshold), m_thr);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cycles > LIMIT) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic run_rand(input int n, input int p_acc, input int p_miss, input int p_rdy);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            acc_valid = ($urandom_range(99) < p_acc);
            acc_miss  = ($urandom_range(99) < p_miss);
            pwr_ready = ($urandom_range(99) < p_rdy);
        end
    endtask

    initial begin
        step(3);
        @(negedge clk);
        chk("R1 shutdown", int'(shutdown), 0);
        chk("R1 wakeup", int'(wakeup), 0);
        chk("R1 stall", int'(stall), 0);
        chk("R1 threshold", int'(threshold), 256);
        @(posedge clk); #1;
        rst_n = 1'b1;
        thr_prev_q = 256;
        cmp_en = 1'b1;
        // R5 and R2: fixed threshold 20, stay idle.
        step(40);
        @(negedge clk);
        chk("R5 fixed threshold", int'(threshold), 20);
        chk("R2 timeout shutdown", int'(shutdown), 1);
        // R3: access to sleeping array.
        @(posedge clk); #1;
        acc_valid = 1'b1; pwr_ready = 1'b0;
        @(negedge clk);
        chk("R4 stall on sleeping access", int'(stall), 1);
        @(posedge clk); #1;
        @(negedge clk);
        chk("R3 shutdown cleared", int'(shutdown), 0);
        chk("R3 wakeup raised", int'(wakeup), 1);
        step(3);
        @(negedge clk);
        chk("R4 wakeup held", int'(wakeup), 1);
        chk("R9 no shutdown while waking", int'(shutdown), 0);
        pwr_ready = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        chk("R4 wakeup released", int'(wakeup), 0);
        acc_valid = 1'b0;
        // Random traffic, fixed mode.
        run_rand(2000, 10, 40, 40);
        // R6 R8: feedback mode with dense misses across windows.
        @(posedge clk); #1;
        fb_mode = 1'b1; setpoint = 13'd40; gain = 4'd2; min_thr = 16'd8;
        run_rand(3 * WIN, 40, 30, 50);
        // R7 upper clamp.
        setpoint = 13'd0; gain = 4'd15;
        run_rand(2 * WIN, 50, 60, 60);
        @(negedge clk);
        chk("R7 upper clamp", int'(threshold), 65535);
        // R7 lower clamp: no traffic.
        @(posedge clk); #1;
        acc_valid = 1'b0; pwr_ready = 1'b1;
        setpoint = 13'd4000; gain = 4'd4; min_thr = 16'd30;
        step(3 * WIN);
        @(negedge clk);
        chk("R7 lower clamp", int'(threshold), 30);
        chk("R2 shutdown after long idle", int'(shutdown), 1);
        // R8: hits only leave the threshold unchanged.
        @(posedge clk); #1;
        setpoint = 13'd0; gain = 4'd0; min_thr = 16'd0;
        run_rand(WIN + 200, 30, 0, 50);
        @(negedge clk);
        chk("R8 hits not counted", int'(threshold), 30);
        cmp_en = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule